// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character into an asynchronous-style serial frame on a single output line. The frame shape is chosen at run time from three inputs: the character length (5 to 9 bits), the parity mode (none, even or odd) and the number of stop bits (1 or 2). Together these give 30 frame formats. Bit timing comes from an external bit-rate enable tick. Each bit on the line lasts exactly one tick period.

A producer offers a character with `inValid`. The block takes it on a cycle where `inValid` and `inReady` are both high. `inReady` is only raised on a tick cycle, and only while the line is idle or the last stop bit is ending. This keeps every frame aligned to the tick grid, and a waiting character can follow the previous frame with no idle gap. The configuration and the character are captured when the frame starts. `busy` marks a frame in flight, and `done` pulses once as each frame ends.

Top module: `serial_frame_tx`

## Requirements
- R1: While no frame is in flight (`busy` low), `txd` is high, including after reset.
- R2: A frame starts only on a clock edge where `inValid` and `inReady` are both high. `inReady` is high exactly on tick cycles while idle or during the final stop bit. On the next cycle `busy` is high and `txd` drives the start bit, low, for one tick period.
- R3: Data bits follow the start bit, least significant first. `cfgDataLen` code 0,1,2,3,4 selects 5,6,7,8,9 bits, and codes 5 to 7 select 9 bits.
- R4: `cfgParity` 2'b01 selects even parity (bit = XOR of the active data bits), 2'b10 selects odd parity (its inverse), and 2'b00 or 2'b11 sends no parity bit. The parity bit goes between the last data bit and the stop bits.
- R5: Data bits above the selected length are not sent and do not affect the parity bit.
- R6: The frame ends with one high stop bit, or two when `cfgTwoStop` is 1.
- R7: `txd` changes only on the cycle after a `bitTick`, so each bit lasts exactly one tick period.
- R8: `inData` and the configuration inputs are captured at frame start. Changing them during a frame does not alter that frame.
- R9: If `inValid` is high during the final stop bit, the next frame's start bit follows at once with no idle bit.
- R10: `done` is high for exactly one cycle, the cycle after the final stop bit's closing tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | Bit-rate enable, one cycle per bit period |
| inValid | input | 1 | Character offered |
| inReady | output | 1 | Character will be taken at this edge |
| inData | input | 9 | Character, LSB sent first |
| cfgDataLen | input | 3 | Length code (0..4 = 5..9 bits, higher = 9) |
| cfgParity | input | 2 | 01 even, 10 odd, 00/11 none |
| cfgTwoStop | input | 1 | 1 = two stop bits |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
The assertions check on every cycle these timing rules: the line stays high whenever the block is idle, `txd` moves only after a tick, a handshake always leads to a low start bit, and `done` never lasts more than one cycle. The assertions cannot show that a frame's contents are correct. That needs the bench's directed scenarios. They sweep all 30 formats and compare every bit, check that bits above the selected length are masked, check that mid-frame input changes are ignored, and check that a second frame follows with no gap.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } txState_t;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic load;        // capture character, drive start bit
    logic shift;       // drive next data bit
    logic sendParity;  // drive parity bit
    logic sendMark;    // drive high (stop or idle)
  } txStrobe_t;

  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

endpackage

// File: rtl/sft_ctrl.sv
module sft_ctrl
  import sft_pkg::*;
#(
  parameter int DATA_MAX = 9,
  parameter int DATA_MIN = 5,
  parameter int CODE_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              inValid,
  input  logic [CODE_W-1:0] cfgDataLen,
  input  logic [1:0]        cfgParity,
  input  logic              cfgTwoStop,
  output logic              inReady,
  output logic              busy,
  output logic              done,
  output txStrobe_t         strobe
);

  localparam int CNT_W = $clog2(DATA_MAX + 1);

  txState_t         state, nextState;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             parOn;
  logic             twoStopLat;
  logic             lastStop;
  logic             accept;

  function automatic logic [CNT_W-1:0] lastIndex(input logic [CODE_W-1:0] code);
    int len;
    len = DATA_MIN + int'(code);
    if (len > DATA_MAX) len = DATA_MAX;
    return CNT_W'(len - 1);
  endfunction

  assign lastStop = (state == ST_STOP1 && !twoStopLat) || (state == ST_STOP2);
  assign inReady  = bitTick && (state == ST_IDLE || lastStop);
  assign accept   = inValid && inReady;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    nextState = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          nextState   = ST_START;
          strobe.load = 1'b1;
        end
      end
      ST_START: begin
        if (bitTick) begin
          nextState    = ST_DATA;
          strobe.shift = 1'b1;
        end
      end
      ST_DATA: begin
        if (bitTick) begin
          if (bitCnt == lastIdx) begin
            if (parOn) begin
              nextState         = ST_PARITY;
              strobe.sendParity = 1'b1;
            end else begin
              nextState       = ST_STOP1;
              strobe.sendMark = 1'b1;
            end
          end else begin
            strobe.shift = 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (bitTick) begin
          nextState       = ST_STOP1;
          strobe.sendMark = 1'b1;
        end
      end
      ST_STOP1, ST_STOP2: begin
        if (bitTick) begin
          if (state == ST_STOP1 && twoStopLat) begin
            nextState       = ST_STOP2;
            strobe.sendMark = 1'b1;
          end else if (accept) begin
            nextState   = ST_START;
            strobe.load = 1'b1;
          end else begin
            nextState       = ST_IDLE;
            strobe.sendMark = 1'b1;
          end
        end
      end
      default: begin
        nextState       = ST_IDLE;
        strobe.sendMark = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      lastIdx    <= '0;
      parOn      <= 1'b0;
      twoStopLat <= 1'b0;
      done       <= 1'b0;
    end else begin
      state <= nextState;
      done  <= bitTick && lastStop;
      if (strobe.load) begin
        lastIdx    <= lastIndex(cfgDataLen);
        parOn      <= (cfgParity == PAR_EVEN) || (cfgParity == PAR_ODD);
        twoStopLat <= cfgTwoStop;
      end
      if (state == ST_START) begin
        bitCnt <= '0;
      end else if (state == ST_DATA && strobe.shift) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sft_datapath.sv
module sft_datapath
  import sft_pkg::*;
#(
  parameter int DATA_MAX = 9,
  parameter int DATA_MIN = 5,
  parameter int CODE_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           strobe,
  input  logic [DATA_MAX-1:0] inData,
  input  logic [CODE_W-1:0]   cfgDataLen,
  input  logic [1:0]          cfgParity,
  output logic                txd
);

  logic [DATA_MAX-1:0] shReg;
  logic [DATA_MAX-1:0] activeMask;
  logic                parReg;
  logic                txdReg;
  logic                parNext;
  int                  activeLen;

  always_comb begin
    activeLen = DATA_MIN + int'(cfgDataLen);
    if (activeLen > DATA_MAX) activeLen = DATA_MAX;
  end

  for (genvar g = 0; g < DATA_MAX; g++) begin : g_mask
    assign activeMask[g] = (g < activeLen);
  end

  assign parNext = (^(inData & activeMask)) ^ (cfgParity == PAR_ODD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      parReg <= 1'b0;
      txdReg <= 1'b1;
    end else if (strobe.load) begin
      shReg  <= inData & activeMask;
      parReg <= parNext;
      txdReg <= 1'b0;
    end else if (strobe.shift) begin
      txdReg <= shReg[0];
      shReg  <= shReg >> 1;
    end else if (strobe.sendParity) begin
      txdReg <= parReg;
    end else if (strobe.sendMark) begin
      txdReg <= 1'b1;
    end
  end

  assign txd = txdReg;

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int DATA_MAX = 9,
  parameter int DATA_MIN = 5,
  parameter int CODE_W   = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitTick,
  input  logic                inValid,
  output logic                inReady,
  input  logic [DATA_MAX-1:0] inData,
  input  logic [CODE_W-1:0]   cfgDataLen,
  input  logic [1:0]          cfgParity,
  input  logic                cfgTwoStop,
  output logic                txd,
  output logic                busy,
  output logic                done
);

  txStrobe_t strobe;

  sft_ctrl #(.DATA_MAX(DATA_MAX), .DATA_MIN(DATA_MIN), .CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .inValid(inValid),
    .cfgDataLen(cfgDataLen), .cfgParity(cfgParity), .cfgTwoStop(cfgTwoStop),
    .inReady(inReady), .busy(busy), .done(done), .strobe(strobe)
  );

  sft_datapath #(.DATA_MAX(DATA_MAX), .DATA_MIN(DATA_MIN), .CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .cfgDataLen(cfgDataLen), .cfgParity(cfgParity), .txd(txd)
  );

endmodule

// File: rtl/sft_checker.sv
module sft_checker (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic inValid,
  input logic inReady,
  input logic txd,
  input logic busy,
  input logic done
);

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txd);

  // R2
  start_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (busy && !txd));

  // R7
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(bitTick) |-> $stable(txd));

  // R10
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  done_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy || !txd));

endmodule

bind serial_frame_tx sft_checker u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .inValid(inValid),
  .inReady(inReady), .txd(txd), .busy(busy), .done(done)
);

// File: tb/serial_frame_tx_test.sv
module serial_frame_tx_test;

  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [8:0] inData = '0;
  logic [2:0] cfgDataLen = '0;
  logic [1:0] cfgParity = '0;
  logic       cfgTwoStop = 1'b0;
  logic       txd, busy, done;
  int         tickCnt;
  int         checks = 0;
  int         fails = 0;

  always #4 clk = ~clk;

  serial_frame_tx uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .inValid(inValid),
    .inReady(inReady), .inData(inData), .cfgDataLen(cfgDataLen),
    .cfgParity(cfgParity), .cfgTwoStop(cfgTwoStop),
    .txd(txd), .busy(busy), .done(done)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= 0;
      bitTick <= 1'b0;
    end else begin
      tickCnt <= (tickCnt == TICK_DIV - 1) ? 0 : tickCnt + 1;
      bitTick <= (tickCnt == TICK_DIV - 2);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void buildExp(input logic [8:0] d, input int code,
                                   input logic [1:0] par, input logic two,
                                   output logic [15:0] bits, output int n);
    int len;
    logic p;
    len  = (code > 4) ? 9 : 5 + code;
    bits = '1;
    n    = 0;
    bits[n] = 1'b0; n++;
    p = 1'b0;
    for (int i = 0; i < len; i++) begin
      bits[n] = d[i]; n++;
      p ^= d[i];
    end
    if (par == 2'b01 || par == 2'b10) begin
      bits[n] = p ^ (par == 2'b10); n++;
    end
    bits[n] = 1'b1; n++;
    if (two) begin
      bits[n] = 1'b1; n++;
    end
  endfunction

  task automatic collect(input int n, output logic [15:0] got);
    got = '1;
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!bitTick);
      got[i] = txd;
    end
  endtask

  task automatic offer(input logic [8:0] d, input int code,
                       input logic [1:0] par, input logic two);
    inValid    = 1'b1;
    inData     = d;
    cfgDataLen = 3'(code);
    cfgParity  = par;
    cfgTwoStop = two;
    while (!inReady) @(negedge clk);
  endtask

  task automatic scramble();
    inValid    = 1'b0;
    inData     = ~inData;
    cfgDataLen = cfgDataLen ^ 3'b011;
    cfgParity  = ~cfgParity;
    cfgTwoStop = ~cfgTwoStop;
  endtask

  task automatic sendFrame(input logic [8:0] d, input int code,
                           input logic [1:0] par, input logic two,
                           input string req);
    logic [15:0] exp, got, m;
    int n;
    buildExp(d, code, par, two, exp, n);
    offer(d, code, par, two);
    @(posedge clk); #1;
    scramble();
    collect(n, got);
    m = 16'((32'd1 << n) - 1);
    check((got & m) == (exp & m), req, "frame bits", int'(got & m), int'(exp & m));
    @(negedge clk);
    check(done == 1'b1, "R10", "done after last stop", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R10", "done one cycle", int'(done), 0);
  endtask

  task automatic testReset();
    check(txd == 1'b1, "R1", "reset txd", int'(txd), 1);
    check(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    check(done == 1'b0, "R10", "reset done", int'(done), 0);
    for (int i = 0; i < 2 * TICK_DIV; i++) begin
      @(negedge clk);
      check(inReady == bitTick, "R2", "idle ready tracks tick", int'(inReady), int'(bitTick));
    end
  endtask

  task automatic testBasic();
    sendFrame(9'h0A5, 3, 2'b00, 1'b0, "R3 R6 8N1");
    sendFrame(9'h0A5, 3, 2'b01, 1'b1, "R4 R6 8E2");
  endtask

  task automatic testAllFormats();
    for (int code = 0; code < 5; code++)
      for (int par = 0; par < 3; par++)
        for (int two = 0; two < 2; two++)
          sendFrame(9'(9'h1B3 ^ (code * 57 + par * 13 + two * 101)), code,
                    2'(par), 1'(two), "R3 R4 R6 sweep");
  endtask

  task automatic testHighBits();
    // R5: bits above 5 are set; 5-bit data 10110 gives even parity 1
    sendFrame(9'h1F6, 0, 2'b01, 1'b0, "R5 masked bits");
    // R3 R4: length code 7 acts as 9 bits, parity code 11 sends no parity
    sendFrame(9'h155, 7, 2'b11, 1'b0, "R3 R4 reserved codes");
  endtask

  task automatic testLatch();
    // R8: sendFrame changes every input right after the start edge
    sendFrame(9'h03C, 2, 2'b10, 1'b1, "R8 latched config");
  endtask

  task automatic testBackToBack();
    logic [15:0] expA, expB, gotA, gotB, mA, mB;
    int nA, nB;
    buildExp(9'h0C3, 3, 2'b10, 1'b0, expA, nA);
    buildExp(9'h05A, 1, 2'b00, 1'b1, expB, nB);
    offer(9'h0C3, 3, 2'b10, 1'b0);
    @(posedge clk); #1;
    inData = 9'h05A; cfgDataLen = 3'd1; cfgParity = 2'b00; cfgTwoStop = 1'b1;
    collect(nA, gotA);
    check(inReady == 1'b1, "R9", "ready in last stop", int'(inReady), 1);
    @(posedge clk); #1;
    scramble();
    collect(nB, gotB);
    mA = 16'((32'd1 << nA) - 1);
    mB = 16'((32'd1 << nB) - 1);
    check((gotA & mA) == (expA & mA), "R9", "first frame", int'(gotA & mA), int'(expA & mA));
    check((gotB & mB) == (expB & mB), "R9", "second frame no gap", int'(gotB & mB), int'(expB & mB));
  endtask

  task automatic testIdle();
    for (int i = 0; i < 3 * TICK_DIV; i++) begin
      @(negedge clk);
    end
    check(txd == 1'b1, "R1", "idle txd", int'(txd), 1);
    check(busy == 1'b0, "R1", "idle busy", int'(busy), 0);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testIdle();
    testAllFormats();
    testHighBits();
    testLatch();
    testBackToBack();
    testIdle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule